// File: doc/BRIEF.md
# Serial Word Shift-Out Sequencer

This block drives a pair of cascaded external shift/storage registers over a three-wire style link. The link has a serial data line, a shift-clock strobe and a latch strobe. It runs on its own with no data input. After reset it sends a fixed 16-bit start-up pattern and latches it. It then waits a long hold period. After that it sends a free-running 16-bit count, one value per fixed interval.

Each value is sent as two bytes, the high byte first and each byte most significant bit first. For each bit, the serial data is placed on the line one cycle before its shift strobe. The data stays unchanged through the strobe. The latch strobe follows the sixteenth shift strobe, and it fires once per value. A busy output marks the span from the data set-up of the first bit through the latch cycle. The hold period, the interval and the count end point are parameters, so a bench can run with short timings.

Top module: `word_shiftout`

## Requirements
- R1: While the active-low reset `rstN` is low, `serData`, `shiftStrobe`, `latchStrobe` and `busy` are all 0.
- R2: The first value sent after reset is 16'hAAF0: the byte 8'hAA first and then the byte 8'hF0. One latch pulse follows it.
- R3: Every value is sent high byte first, and each byte most significant bit first. The sixteen bits a receiver captures, shifted in from the LSB side, equal the value.
- R4: In the cycle before each `shiftStrobe` pulse, `serData` already holds the bit being shifted. It does not change in the strobe cycle.
- R5: `shiftStrobe` and `latchStrobe` are single-cycle pulses and are never high in the same cycle. Exactly 16 shift strobes come before each latch strobe.
- R6: The latch of count value 0 comes exactly `HOLD_CYCLES` clock cycles after the latch of the start-up pattern.
- R7: Latches of successive count values are exactly `INTERVAL_CYCLES` clock cycles apart.
- R8: The count values sent are 0, 1, 2, ... up to `COUNT_END`-1 (default 16'hFFFE). The count then starts again at 0.
- R9: `busy` is 1 in every cycle from the set-up cycle of a value's first bit through its latch cycle. It is 0 in the cycle after a latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serData | output | 1 | Serial data to the first shift register |
| shiftStrobe | output | 1 | One-cycle shift-clock pulse |
| latchStrobe | output | 1 | One-cycle storage-register latch pulse |
| busy | output | 1 | High while a value is being sent and latched |

## Verification
Suppose the bit counter in the control goes wrong. The very next latch then shows a strobe count other than 16, and the captured word is wrong. Suppose instead the wait timer or the hold/interval selector goes wrong. The latch-to-latch distance then differs from `HOLD_CYCLES` or `INTERVAL_CYCLES` at the next latch. A wrong count register shows as a bad word in the same frame, or at the wrap point `COUNT_END`-1 to 0, which the bench forces with a small end value. A wrong shift register or set-up timing shows within one strobe as a `serData` value that changed at the strobe.

// File: rtl/shiftout_pkg.sv
package shiftout_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2,
    ST_WAIT  = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPattern; // load the start-up pattern into the shifter
    logic loadCount;   // load the current count and advance it
    logic shiftNow;    // move the shifter one bit towards the MSB
  } dpCtl_t;

endpackage

// File: rtl/shiftout_datapath.sv
module shiftout_datapath
  import shiftout_pkg::*;
#(
  parameter int              WORD_W    = 16,
  parameter logic [WORD_W-1:0] PATTERN   = 16'hAAF0,
  parameter logic [WORD_W-1:0] COUNT_END = 16'hFFFF
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t ctl,
  output logic   serData
);

  localparam logic [WORD_W-1:0] LAST_COUNT = COUNT_END - 1'b1;

  logic [WORD_W-1:0] shReg;
  logic [WORD_W-1:0] countReg;
  logic [WORD_W-1:0] countNext;
  logic [WORD_W-1:0] shShifted;

  // Count advance with wrap at the end value
  always_comb begin
    if (countReg == LAST_COUNT) countNext = '0;
    else                        countNext = countReg + 1'b1;
  end

  // Shift towards the MSB; the bit leaving at the top is the one on the line
  genvar g;
  generate
    for (g = 1; g < WORD_W; g++) begin : g_shift
      assign shShifted[g] = shReg[g-1];
    end
  endgenerate
  assign shShifted[0] = 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      countReg <= '0;
    end else begin
      if (ctl.loadPattern) begin
        shReg <= PATTERN;
      end else if (ctl.loadCount) begin
        shReg    <= countReg;
        countReg <= countNext;
      end else if (ctl.shiftNow) begin
        shReg <= shShifted;
      end
    end
  end

  assign serData = shReg[WORD_W-1];

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    countReg < COUNT_END);

  // R3
  msb_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftNow |=> serData == $past(shReg[WORD_W-2]));

endmodule

// File: rtl/shiftout_ctrl.sv
module shiftout_ctrl
  import shiftout_pkg::*;
#(
  parameter int WORD_W          = 16,
  parameter int HOLD_CYCLES     = 625_000_000,
  parameter int INTERVAL_CYCLES = 6_250_000
) (
  input  logic   clk,
  input  logic   rstN,
  output dpCtl_t ctl,
  output logic   shiftStrobe,
  output logic   latchStrobe,
  output logic   busy
);

  // Cycles spent per value: set-up plus strobe per bit, then one latch cycle
  localparam int FRAME_CYCLES = 2 * WORD_W + 1;
  localparam int HOLD_GAP     = HOLD_CYCLES - FRAME_CYCLES;
  localparam int INT_GAP      = INTERVAL_CYCLES - FRAME_CYCLES;
  localparam int MAX_GAP      = (HOLD_GAP > INT_GAP) ? HOLD_GAP : INT_GAP;
  localparam int TMR_W        = $clog2(MAX_GAP + 1);
  localparam int BIT_W        = $clog2(WORD_W);
  localparam logic [TMR_W-1:0] HOLD_LOAD = TMR_W'(HOLD_GAP - 1);
  localparam logic [TMR_W-1:0] INT_LOAD  = TMR_W'(INT_GAP - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);

  seqState_t         state;
  logic              phase;     // 0: data set-up cycle, 1: strobe cycle
  logic [BIT_W-1:0]  bitCnt;
  logic [TMR_W-1:0]  timer;
  logic              firstWait; // next wait is the start-up hold

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_START;
      phase     <= 1'b0;
      bitCnt    <= '0;
      timer     <= '0;
      firstWait <= 1'b1;
    end else begin
      unique case (state)
        ST_START: begin
          state  <= ST_SHIFT;
          phase  <= 1'b0;
          bitCnt <= '0;
        end
        ST_SHIFT: begin
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (bitCnt == LAST_BIT) state  <= ST_LATCH;
            else                    bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_LATCH: begin
          state     <= ST_WAIT;
          bitCnt    <= '0;
          timer     <= firstWait ? HOLD_LOAD : INT_LOAD;
          firstWait <= 1'b0;
        end
        ST_WAIT: begin
          if (timer == '0) begin
            state <= ST_SHIFT;
            phase <= 1'b0;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: state <= ST_START;
      endcase
    end
  end

  always_comb begin
    ctl.loadPattern = (state == ST_START);
    ctl.loadCount   = (state == ST_WAIT) && (timer == '0);
    ctl.shiftNow    = (state == ST_SHIFT) && phase;
  end

  assign shiftStrobe = (state == ST_SHIFT) && phase;
  assign latchStrobe = (state == ST_LATCH);
  assign busy        = (state == ST_SHIFT) || (state == ST_LATCH);

  // R5
  latch_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchStrobe |-> $past(shiftStrobe));

  // R5
  latch_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchStrobe |=> !latchStrobe);

  // R9
  busy_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchStrobe |=> !busy);

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && timer != '0) |=> (state == ST_WAIT) && !busy);

endmodule

// File: rtl/word_shiftout.sv
module word_shiftout
  import shiftout_pkg::*;
#(
  parameter int BYTE_W          = 8,
  parameter int NUM_BYTES       = 2,
  parameter int HOLD_CYCLES     = 625_000_000,
  parameter int INTERVAL_CYCLES = 6_250_000,
  parameter logic [BYTE_W*NUM_BYTES-1:0] PATTERN   = 16'hAAF0,
  parameter logic [BYTE_W*NUM_BYTES-1:0] COUNT_END = 16'hFFFF
) (
  input  logic clk,
  input  logic rstN,
  output logic serData,
  output logic shiftStrobe,
  output logic latchStrobe,
  output logic busy
);

  localparam int WORD_W = BYTE_W * NUM_BYTES;

  dpCtl_t ctl;

  shiftout_ctrl #(
    .WORD_W         (WORD_W),
    .HOLD_CYCLES    (HOLD_CYCLES),
    .INTERVAL_CYCLES(INTERVAL_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .shiftStrobe(shiftStrobe),
    .latchStrobe(latchStrobe),
    .busy       (busy)
  );

  shiftout_datapath #(
    .WORD_W   (WORD_W),
    .PATTERN  (PATTERN),
    .COUNT_END(COUNT_END)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .serData(serData)
  );

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftStrobe && latchStrobe));

  // R4
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftStrobe |-> $stable(serData));

endmodule

// File: tb/word_shiftout_bench.sv
`timescale 1ns/1ps
module word_shiftout_bench;

  localparam int HOLD     = 60;
  localparam int INTERVAL = 40;
  localparam int LIMIT    = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serData, shiftStrobe, latchStrobe, busy;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  word_shiftout #(
    .HOLD_CYCLES    (HOLD),
    .INTERVAL_CYCLES(INTERVAL),
    .COUNT_END      (16'(LIMIT))
  ) u_word_shiftout (
    .clk        (clk),
    .rstN       (rstN),
    .serData    (serData),
    .shiftStrobe(shiftStrobe),
    .latchStrobe(latchStrobe),
    .busy       (busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected word for the n-th latch after reset (0 = start-up pattern)
  function automatic logic [15:0] expWord(input int n);
    if (n == 0) return 16'hAAF0;
    return 16'((n - 1) % LIMIT);
  endfunction

  // Monitor state
  logic [15:0] capWord = '0;
  int  bitsSeen  = 0;
  int  latchNo   = 0;
  int  cycle     = 0;
  int  lastLatch = 0;
  bit  prevSer   = 1'b0;
  bit  gapCheck  = 1'b0;
  bit  wrapSeen  = 1'b0;

  always @(negedge clk) begin
    cycle++;
    if (!rstN) begin
      // R1
      check({serData, shiftStrobe, latchStrobe, busy} == 4'b0000, "R1 reset outputs",
            {serData, shiftStrobe, latchStrobe, busy}, 0);
      bitsSeen = 0; latchNo = 0; gapCheck = 1'b0; capWord = '0;
    end else begin
      // R5 exclusion
      if (shiftStrobe && latchStrobe)
        check(1'b0, "R5 strobes together", 1, 0);
      if (shiftStrobe) begin
        check(serData == prevSer, "R4 data set-up", serData, prevSer);
        check(busy, "R9 busy during shift", busy, 1);
        capWord = {capWord[14:0], serData};
        bitsSeen++;
      end
      if (latchStrobe) begin
        check(bitsSeen == 16, "R5 strobes per latch", bitsSeen, 16);
        check(busy, "R9 busy at latch", busy, 1);
        if (latchNo == 0)
          check(capWord == expWord(0), "R2 start-up pattern", capWord, expWord(0));
        else
          check(capWord == expWord(latchNo), "R3 R8 count word", capWord, expWord(latchNo));
        if (latchNo == 1)
          check(cycle - lastLatch == HOLD, "R6 hold length", cycle - lastLatch, HOLD);
        if (latchNo >= 2)
          check(cycle - lastLatch == INTERVAL, "R7 interval", cycle - lastLatch, INTERVAL);
        if (latchNo > 1 && capWord == 16'd0) wrapSeen = 1'b1;
        lastLatch = cycle;
        latchNo++;
        bitsSeen = 0;
        gapCheck = 1'b1;
      end else if (gapCheck) begin
        check(!busy, "R9 idle after latch", busy, 0);
        gapCheck = 1'b0;
      end
    end
    prevSer = serData;
  end

  task automatic runCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    runCycles(5);
    rstN = 1'b1;
    // Directed: long run reaching the count wrap (R8)
    runCycles(HOLD + INTERVAL * (2 * LIMIT + 2) + 40);
    // Directed: reset during the start-up frame, then restart (R1, R2)
    rstN = 1'b0;
    runCycles(2);
    rstN = 1'b1;
    runCycles(10);
    rstN = 1'b0;
    runCycles(3);
    rstN = 1'b1;
    // Random reset points and run lengths
    for (int i = 0; i < 12; i++) begin
      runCycles($urandom_range(30, 700));
      rstN = 1'b0;
      runCycles($urandom_range(1, 4));
      rstN = 1'b1;
    end
    runCycles(HOLD + INTERVAL * 3 + 40);
    check(wrapSeen, "R8 wrap to zero observed", wrapSeen, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule